// File: doc/BRIEF.md
# Execution Context Access Guard

This block sits beside a small soft CPU and decides, cycle by cycle, which memories the CPU may touch given the privilege context it is in. It holds a one-bit mode register: zero is firmware mode, one is application mode. The register moves to application mode on its own when an instruction is fetched from an address outside the firmware ROM window. It can also be loaded by a store to the mode register. A syscall interrupt context code from the CPU wrapper then widens the permissions again while a syscall handler runs.

Three effects follow from the mode and the context code. Firmware RAM gets a generic enable input instead of the raw mode bit. ROM fetches are either passed through or replaced with an all-zero illegal instruction word, and the replacement raises an error flag. The first real rise of the mode to one sets a permanent asset-lock flag, which stays set until reset. Two interrupt sources are also included. Each one is raised by a store to its own address and is held until the CPU acknowledges it.

Top module: `exec_ctx_guard`

## Requirements
- R1: After reset, app_mode, asset_lock and both irq bits are 0, and fw_ram_en and rom_fetch_en are 1.
- R2: A cycle with fetch_valid=1 and fetch_addr outside the ROM window sets app_mode to 1 at the next clock edge. A fetch inside the window leaves app_mode unchanged.
- R3: A cycle with mode_wr=1 loads mode_wdata into app_mode at the next edge. This write takes priority over the automatic switch of R2.
- R4: asset_lock goes to 1 at the edge after app_mode has risen from 0 to 1. Writes of 0 while app_mode is 0 never set it.
- R5: Once set, asset_lock stays 1 until reset, including after app_mode returns to 0.
- R6: fw_ram_en is 1 exactly when app_mode is 0 or irq_ctx is 2'b10 (high-priority syscall).
- R7: rom_fetch_en is 1 exactly when app_mode is 0 or irq_ctx is 2'b01 (low-priority syscall) or 2'b10. Codes 2'b00 (no syscall) and 2'b11 deny ROM fetches in application mode.
- R8: A fetch with fetch_valid=1, an address inside the ROM window and rom_fetch_en=0 gives fetch_err=1 and fetch_rdata=0. In every other case fetch_err=0 and fetch_rdata equals rom_rdata. Both outputs are combinational.
- R9: A store (bus_wr=1) to IRQ0_ADDR sets irq[0], and a store to IRQ1_ADDR sets irq[1], at the next edge. Stores to other addresses leave both bits unchanged.
- R10: Each irq bit stays 1 until its irq_ack bit is 1 at a clock edge. A store and an ack for the same source in the same cycle leave the bit at 1.
- R11: The ROM window is [ROM_BASE, ROM_BASE+ROM_SIZE). ROM_BASE and ROM_BASE+ROM_SIZE-1 are inside it. ROM_BASE-1 and ROM_BASE+ROM_SIZE are outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Instruction fetch in progress |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| rom_rdata | input | DATA_W | Word read from ROM |
| irq_ctx | input | 2 | Syscall context: 00 none, 01 low, 10 high, 11 treated as none |
| mode_wr | input | 1 | Store strobe to the mode register |
| mode_wdata | input | 1 | Value stored to the mode register |
| bus_wr | input | 1 | Data store strobe |
| bus_addr | input | ADDR_W | Data store address |
| irq_ack | input | 2 | Per-source interrupt acknowledge |
| fetch_rdata | output | DATA_W | Fetched word, or zero when denied |
| fetch_err | output | 1 | Denied ROM fetch |
| fw_ram_en | output | 1 | Firmware RAM enable |
| rom_fetch_en | output | 1 | ROM fetch permission |
| asset_lock | output | 1 | Permanent asset lock |
| app_mode | output | 1 | Application mode flag |
| irq | output | 2 | Interrupt request lines |

## Verification
The bench fetches from both edges of the ROM window and from one address beyond each edge. A comparator that is off by one would switch modes on the last ROM word, or would fail to switch on the first word past it. It writes zero to the mode register repeatedly before any switch, and it returns to firmware mode after the lock is set. A lock that keys on the write strobe, or one that clears, shows up as a wrong asset_lock. Random runs cover every irq_ctx code in application mode, including 2'b11, and the case where a store and an ack for the same source land in the same cycle, where a design that lets the ack win would drop the request.

// File: rtl/exec_ctx_guard.sv
module exec_ctx_guard #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] ROM_SIZE  = 32'h0000_2000,
  parameter logic [ADDR_W-1:0] IRQ0_ADDR = 32'hFF00_0000,
  parameter logic [ADDR_W-1:0] IRQ1_ADDR = 32'hFF00_0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [1:0]        irq_ctx,
  input  logic              mode_wr,
  input  logic              mode_wdata,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        irq_ack,
  output logic [DATA_W-1:0] fetch_rdata,
  output logic              fetch_err,
  output logic              fw_ram_en,
  output logic              rom_fetch_en,
  output logic              asset_lock,
  output logic              app_mode,
  output logic [1:0]        irq
);

  localparam logic [1:0] CTX_LO = 2'b01;
  localparam logic [1:0] CTX_HI = 2'b10;
  localparam logic [ADDR_W-1:0] IRQ_ADDR [2] = '{IRQ0_ADDR, IRQ1_ADDR};

  logic [ADDR_W-1:0] rom_off;
  logic              rom_hit;
  logic              app_q;

  assign rom_off = fetch_addr - ROM_BASE;
  assign rom_hit = (fetch_addr >= ROM_BASE) && (rom_off < ROM_SIZE);

  assign fw_ram_en    = !app_mode || (irq_ctx == CTX_HI);
  assign rom_fetch_en = !app_mode || (irq_ctx == CTX_LO) || (irq_ctx == CTX_HI);
  assign fetch_err    = fetch_valid && rom_hit && !rom_fetch_en;
  assign fetch_rdata  = fetch_err ? '0 : rom_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_mode   <= 1'b0;
      app_q      <= 1'b0;
      asset_lock <= 1'b0;
    end else begin
      if (mode_wr)
        app_mode <= mode_wdata;
      else if (fetch_valid && !rom_hit)
        app_mode <= 1'b1;
      app_q <= app_mode;
      if (app_mode && !app_q)
        asset_lock <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (bus_wr && bus_addr == IRQ_ADDR[i])
          irq[i] <= 1'b1;
        else if (irq_ack[i])
          irq[i] <= 1'b0;
      end
    end
  end

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    asset_lock |=> asset_lock);

  p_lock_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asset_lock) |-> $past(app_mode && !app_q));

  p_auto_app_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !rom_hit && !mode_wr) |=> app_mode);

  p_deny_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> (fetch_rdata == '0 && rom_hit && app_mode));

  p_irq0_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] && !irq_ack[0]) |=> irq[0]);

  p_irq1_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[1] && !irq_ack[1]) |=> irq[1]);

  p_ram_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (app_mode && irq_ctx != CTX_HI) |-> !fw_ram_en);

endmodule

// File: tb/exec_ctx_guard_tb_top.sv
module exec_ctx_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RB = 32'h0000_1000;
  localparam logic [31:0] RS = 32'h0000_2000;
  localparam logic [31:0] IA0 = 32'hFF00_0000;
  localparam logic [31:0] IA1 = 32'hFF00_0004;

  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, mode_wr = 0, mode_wdata = 0, bus_wr = 0;
  logic [31:0] fetch_addr = 0, rom_rdata = 0, bus_addr = 0, fetch_rdata;
  logic [1:0] irq_ctx = 0, irq_ack = 0, irq;
  logic fetch_err, fw_ram_en, rom_fetch_en, asset_lock, app_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic m_app, m_appq, m_lock;
  logic [1:0] m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_ctx_guard dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .rom_rdata(rom_rdata), .irq_ctx(irq_ctx), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .irq_ack(irq_ack), .fetch_rdata(fetch_rdata),
    .fetch_err(fetch_err), .fw_ram_en(fw_ram_en), .rom_fetch_en(rom_fetch_en),
    .asset_lock(asset_lock), .app_mode(app_mode), .irq(irq));

  function automatic bit in_rom(logic [31:0] a);
    return (a >= RB) && (a < RB + RS);
  endfunction
  function automatic bit exp_ram(logic app, logic [1:0] c);
    return !app || c == 2'b10;
  endfunction
  function automatic bit exp_rom(logic app, logic [1:0] c);
    return !app || c == 2'b01 || c == 2'b10;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_app = 0; m_appq = 0; m_lock = 0; m_irq = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fetch_valid = 0; mode_wr = 0; bus_wr = 0; irq_ack = 0; irq_ctx = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    check(app_mode == 0 && asset_lock == 0 && irq == 0, "R1 state",
          {29'd0, app_mode, asset_lock, 1'b0} | {30'd0, irq}, 0);
    check(fw_ram_en && rom_fetch_en, "R1 enables", {fw_ram_en, rom_fetch_en}, 3);
  endtask

  task automatic step(bit fv, logic [31:0] fa, logic [1:0] ctx, bit mw, bit md,
                      bit bw, logic [31:0] ba, logic [1:0] ack);
    bit e_err;
    logic [1:0] nirq;
    @(negedge clk);
    fetch_valid = fv; fetch_addr = fa; irq_ctx = ctx; mode_wr = mw; mode_wdata = md;
    bus_wr = bw; bus_addr = ba; irq_ack = ack; rom_rdata = $urandom | 32'h1;
    #1;
    e_err = fv && in_rom(fa) && !exp_rom(m_app, ctx);
    check(fw_ram_en == exp_ram(m_app, ctx), "R6 fw_ram_en", fw_ram_en, exp_ram(m_app, ctx));
    check(rom_fetch_en == exp_rom(m_app, ctx), "R7 rom_fetch_en", rom_fetch_en, exp_rom(m_app, ctx));
    check(fetch_err == e_err, "R8 fetch_err", fetch_err, e_err);
    check(fetch_rdata == (e_err ? 32'd0 : rom_rdata), "R8 fetch_rdata", fetch_rdata,
          e_err ? 32'd0 : rom_rdata);
    for (int i = 0; i < 2; i++)
      nirq[i] = (bw && ba == (i == 0 ? IA0 : IA1)) ? 1'b1 : (ack[i] ? 1'b0 : m_irq[i]);
    m_lock = m_lock | (m_app & !m_appq);
    m_appq = m_app;
    m_app = mw ? md : ((fv && !in_rom(fa)) ? 1'b1 : m_app);
    m_irq = nirq;
    @(posedge clk); #1;
    check(app_mode == m_app, "R2 R3 app_mode", app_mode, m_app);
    check(asset_lock == m_lock, "R4 R5 asset_lock", asset_lock, m_lock);
    check(irq == m_irq, "R9 R10 irq", irq, m_irq);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom % 8)
      0: return RB;
      1: return RB + RS - 1;
      2: return RB - 1;
      3: return RB + RS;
      4, 5, 6: return RB + ($urandom % RS);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R4: zero writes and in-ROM fetches in firmware mode never lock
    for (int i = 0; i < 6; i++) step(1, RB + i * 4, 0, 1, 0, 0, 0, 0);
    check(asset_lock == 0 && app_mode == 0, "R4 no lock on zero write", asset_lock, 0);
    // R11 boundaries inside
    step(1, RB, 0, 0, 0, 0, 0, 0);
    step(1, RB + RS - 1, 0, 0, 0, 0, 0, 0);
    check(app_mode == 0, "R11 last ROM word inside", app_mode, 0);
    // R11 just past end
    step(1, RB + RS, 0, 0, 0, 0, 0, 0);
    check(app_mode == 1, "R11 end+1 outside", app_mode, 1);
    idle();
    check(asset_lock == 1, "R4 lock after rise", asset_lock, 1);
    // R7 R8 denied ROM fetch in app mode
    step(1, RB, 2'b00, 0, 0, 0, 0, 0);
    step(1, RB, 2'b11, 0, 0, 0, 0, 0);
    step(1, RB, 2'b01, 0, 0, 0, 0, 0);
    step(1, RB, 2'b10, 0, 0, 0, 0, 0);
    // R5 back to firmware, lock remains
    step(0, 0, 0, 1, 0, 0, 0, 0);
    idle();
    check(asset_lock == 1 && app_mode == 0, "R5 lock held", asset_lock, 1);
    // R11 below base
    do_reset();
    step(1, RB - 1, 0, 0, 0, 0, 0, 0);
    check(app_mode == 1, "R11 base-1 outside", app_mode, 1);
    // R3 write beats auto switch
    do_reset();
    step(1, 32'h0, 0, 1, 0, 0, 0, 0);
    check(app_mode == 0, "R3 write priority", app_mode, 0);
    // R9 R10 irq set, hold, ack, set+ack
    step(0, 0, 0, 0, 0, 1, IA0, 0);
    step(0, 0, 0, 0, 0, 1, 32'hFF00_0008, 0);
    idle(); idle();
    check(irq == 2'b01, "R10 irq0 held", irq, 2'b01);
    step(0, 0, 0, 0, 0, 1, IA1, 2'b01);
    check(irq == 2'b10, "R9 irq1 set, irq0 acked", irq, 2'b10);
    step(0, 0, 0, 0, 0, 1, IA1, 2'b10);
    check(irq == 2'b10, "R10 set beats ack", irq, 2'b10);
    step(0, 0, 0, 0, 0, 0, 0, 2'b10);
    // random phase with occasional resets
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ba;
      if (n % 700 == 699) do_reset();
      case ($urandom % 4)
        0: ba = IA0;
        1: ba = IA1;
        2: ba = IA0 + 32'd8;
        default: ba = $urandom;
      endcase
      step($urandom % 4 != 0, pick_addr(), 2'($urandom), ($urandom % 6) == 0, 1'($urandom),
           ($urandom % 3) == 0, ba, 2'($urandom % 4 == 0 ? $urandom : 0));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule